// File: doc/BRIEF.md
# Key-Protected Core Power-Mode Controller

This block holds one 32-bit control word that chooses the power state of a secondary processor core. The low two bits select one of four modes (off, held in reset, retained, running). The block decodes the mode into five control lines: rail power enable, clock enable, output isolation, core reset and state retention. A write is accepted only when its upper half-word carries a fixed unlock key. Stray or corrupted writes therefore cannot disturb a running core.

The retained mode is conditional. It is applied only once the controlled core reports that it is in deep sleep. Until then the control lines keep their previous values. Every move from an unpowered mode (off or retained) to a powered one (reset or running) passes through a one-cycle power-up step: the rail comes back first, while clock, isolation and reset stay safe. A done flag tells software when the applied state has caught up with the requested mode.

A managing processor normally programs the block while the controlled core is asleep. Readback returns the requested mode with a constant signature in the upper half-word.

Top module: `core_pwr_ctl`

## Requirements
- R1: After reset the register reads 0xFA050001. The outputs show the reset mode (power on, clock off, isolation off, reset asserted, retention off), and the done flag is high.
- R2: A write whose bits [31:16] equal 0x05FA is accepted. It loads bits [1:0] into the mode field, and the new value is visible on the read bus after the write's clock edge.
- R3: A write whose bits [31:16] differ from 0x05FA leaves the read value, the outputs and the done flag unchanged.
- R4: Read bits [31:16] are always 0xFA05 and read bits [15:2] are always zero, whatever was written to them.
- R5: Mode 0 (off) applies power off, clock off, isolation on, reset asserted and retention off.
- R6: Mode 1 (reset) applies power on, clock off, isolation off, reset asserted and retention off.
- R7: Mode 3 (running) applies power on, clock on, isolation off, reset released and retention off. The clock is never enabled without power.
- R8: Mode 2 (retained) applies power off, clock off, isolation on, reset released and retention on. This happens only on the clock edge after the deep-sleep input has been seen high. While deep sleep is low the outputs hold their previous state. Once retention is applied, a later drop of deep sleep does not undo it.
- R9: Moving from mode 0 or 2 to mode 1 or 3 first spends exactly one cycle with power on, clock off, isolation on, reset asserted and retention off. The target outputs follow on the next edge.
- R10: The done flag rises one clock after the applied outputs match the requested mode. An accepted write that changes the mode clears it on that write's edge. An accepted write of the same mode leaves it high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 32 | Write data: key in [31:16], mode in [1:0] |
| rd_data | output | 32 | Read data: 0xFA05 signature, zeros, requested mode |
| core_deep_sleep | input | 1 | Controlled core reports deep sleep |
| pwr_en | output | 1 | Rail power enable |
| clk_en | output | 1 | Core clock enable |
| iso_en | output | 1 | Output isolation enable |
| core_rst | output | 1 | Core reset, active high |
| ret_en | output | 1 | State retention enable |
| state_done | output | 1 | Applied state matches the requested mode |

## Verification
The assertions take the deep-sleep input to be a level that is synchronous to the block clock. They also take each write strobe to be a single-cycle pulse with stable data in that cycle, so that the check comparing the mode before and after a write compares against one write only. The bench drives every input on the falling edge, holds deep sleep steady across each write, and changes it only between writes. It never issues two writes back to back while a power-up step is under way.

// File: rtl/core_pwr_pkg.sv
package core_pwr_pkg;

   localparam int MODE_W = 2;

   typedef enum logic [MODE_W-1:0] {
      PM_OFF    = 2'd0,
      PM_RESET  = 2'd1,
      PM_RETAIN = 2'd2,
      PM_ON     = 2'd3
   } pmode_e;

   typedef struct packed {
      logic pwr;
      logic clk;
      logic iso;
      logic rst;
      logic ret;
   } pctl_t;

   // Control word used during the single power-up step.
   localparam pctl_t PCTL_PWRUP = '{pwr: 1'b1, clk: 1'b0, iso: 1'b1, rst: 1'b1, ret: 1'b0};

   function automatic pctl_t mode_decode(input pmode_e m);
      pctl_t c;
      unique case (m)
         PM_OFF:    c = '{pwr: 1'b0, clk: 1'b0, iso: 1'b1, rst: 1'b1, ret: 1'b0};
         PM_RESET:  c = '{pwr: 1'b1, clk: 1'b0, iso: 1'b0, rst: 1'b1, ret: 1'b0};
         PM_RETAIN: c = '{pwr: 1'b0, clk: 1'b0, iso: 1'b1, rst: 1'b0, ret: 1'b1};
         default:   c = '{pwr: 1'b1, clk: 1'b1, iso: 1'b0, rst: 1'b0, ret: 1'b0};
      endcase
      return c;
   endfunction

   function automatic logic mode_powered(input pmode_e m);
      return (m == PM_RESET) || (m == PM_ON);
   endfunction

endpackage

// File: rtl/pwr_key_reg.sv
module pwr_key_reg
   import core_pwr_pkg::*;
#(
   parameter int          DATA_W     = 32,
   parameter int          KEY_W      = 16,
   parameter logic [15:0] KEY_WRITE  = 16'h05FA,
   parameter logic [15:0] KEY_READ   = 16'hFA05,
   parameter int          RESET_MODE = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output pmode_e            mode_q,
   output logic              mode_change,
   output logic [DATA_W-1:0] rd_data
);

   localparam int PAD_W = DATA_W - KEY_W - MODE_W;

   logic   key_ok;
   logic   accept;
   pmode_e wr_mode;

   assign key_ok      = (wr_data[DATA_W-1 -: KEY_W] == KEY_WRITE[KEY_W-1:0]);
   assign accept      = wr_en && key_ok;
   assign wr_mode     = pmode_e'(wr_data[MODE_W-1:0]);
   assign mode_change = accept && (wr_mode != mode_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= pmode_e'(RESET_MODE[MODE_W-1:0]);
      end else if (accept) begin
         mode_q <= wr_mode;
      end
   end

   generate
      if (PAD_W > 0) begin : g_pad
         assign rd_data = {KEY_READ[KEY_W-1:0], {PAD_W{1'b0}}, mode_q};
      end else begin : g_nopad
         assign rd_data = {KEY_READ[KEY_W-1:0], mode_q};
      end
   endgenerate

endmodule

// File: rtl/pwr_apply_seq.sv
module pwr_apply_seq
   import core_pwr_pkg::*;
#(
   parameter int RESET_MODE = 1
) (
   input  logic   clk,
   input  logic   rst_n,
   input  pmode_e mode_req,
   input  logic   mode_change,
   input  logic   deep_sleep,
   output pmode_e app_q,
   output logic   pwrup_q,
   output logic   done_q
);

   pmode_e target;
   logic   need_pwrup;

   // Retained mode waits for deep sleep; until then hold what is applied.
   always_comb begin
      if (mode_req == PM_RETAIN && !deep_sleep) begin
         target = app_q;
      end else begin
         target = mode_req;
      end
   end

   assign need_pwrup = !mode_powered(app_q) && mode_powered(target);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         app_q   <= pmode_e'(RESET_MODE[MODE_W-1:0]);
         pwrup_q <= 1'b0;
      end else if (pwrup_q) begin
         app_q   <= target;
         pwrup_q <= 1'b0;
      end else if (need_pwrup) begin
         pwrup_q <= 1'b1;
      end else begin
         app_q   <= target;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q <= 1'b1;
      end else if (mode_change) begin
         done_q <= 1'b0;
      end else begin
         done_q <= (app_q == mode_req) && !pwrup_q;
      end
   end

endmodule

// File: rtl/pwr_out_decode.sv
module pwr_out_decode
   import core_pwr_pkg::*;
#(
   parameter bit OUT_REG    = 1'b0,
   parameter int RESET_MODE = 1
) (
   input  logic   clk,
   input  logic   rst_n,
   input  pmode_e app_q,
   input  logic   pwrup_q,
   input  logic   done_in,
   output pctl_t  ctl,
   output logic   done_out
);

   pctl_t ctl_d;

   assign ctl_d = pwrup_q ? PCTL_PWRUP : mode_decode(app_q);

   generate
      if (OUT_REG) begin : g_reg
         pctl_t ctl_r;
         logic  done_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ctl_r  <= mode_decode(pmode_e'(RESET_MODE[MODE_W-1:0]));
               done_r <= 1'b1;
            end else begin
               ctl_r  <= ctl_d;
               done_r <= done_in;
            end
         end
         assign ctl      = ctl_r;
         assign done_out = done_r;
      end else begin : g_comb
         assign ctl      = ctl_d;
         assign done_out = done_in;
      end
   endgenerate

endmodule

// File: rtl/core_pwr_ctl.sv
module core_pwr_ctl
   import core_pwr_pkg::*;
#(
   parameter int          DATA_W     = 32,
   parameter int          KEY_W      = 16,
   parameter logic [15:0] KEY_WRITE  = 16'h05FA,
   parameter logic [15:0] KEY_READ   = 16'hFA05,
   parameter int          RESET_MODE = 1,
   parameter bit          OUT_REG    = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   input  logic              core_deep_sleep,
   output logic              pwr_en,
   output logic              clk_en,
   output logic              iso_en,
   output logic              core_rst,
   output logic              ret_en,
   output logic              state_done
);

   generate
      if (KEY_W < 1 || KEY_W > 16) begin : g_bad_key
         $error("KEY_W must lie in 1..16");
      end
      if (DATA_W < KEY_W + MODE_W) begin : g_bad_width
         $error("DATA_W too small for key and mode fields");
      end
      if (RESET_MODE < 0 || RESET_MODE > 3) begin : g_bad_reset
         $error("RESET_MODE must lie in 0..3");
      end
   endgenerate

   pmode_e mode_q;
   pmode_e app_q;
   logic   mode_change;
   logic   pwrup_q;
   logic   done_q;
   pctl_t  ctl;

   pwr_key_reg #(
      .DATA_W     (DATA_W),
      .KEY_W      (KEY_W),
      .KEY_WRITE  (KEY_WRITE),
      .KEY_READ   (KEY_READ),
      .RESET_MODE (RESET_MODE)
   ) u_key_reg (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .wr_data     (wr_data),
      .mode_q      (mode_q),
      .mode_change (mode_change),
      .rd_data     (rd_data)
   );

   pwr_apply_seq #(
      .RESET_MODE (RESET_MODE)
   ) u_apply (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode_req    (mode_q),
      .mode_change (mode_change),
      .deep_sleep  (core_deep_sleep),
      .app_q       (app_q),
      .pwrup_q     (pwrup_q),
      .done_q      (done_q)
   );

   pwr_out_decode #(
      .OUT_REG    (OUT_REG),
      .RESET_MODE (RESET_MODE)
   ) u_decode (
      .clk      (clk),
      .rst_n    (rst_n),
      .app_q    (app_q),
      .pwrup_q  (pwrup_q),
      .done_in  (done_q),
      .ctl      (ctl),
      .done_out (state_done)
   );

   assign pwr_en   = ctl.pwr;
   assign clk_en   = ctl.clk;
   assign iso_en   = ctl.iso;
   assign core_rst = ctl.rst;
   assign ret_en   = ctl.ret;

endmodule

// File: rtl/core_pwr_ctl_chk.sv
module core_pwr_ctl_chk #(
   parameter int          DATA_W    = 32,
   parameter int          KEY_W     = 16,
   parameter logic [15:0] KEY_WRITE = 16'h05FA,
   parameter logic [15:0] KEY_READ  = 16'hFA05
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [DATA_W-1:0] wr_data,
   input logic [DATA_W-1:0] rd_data,
   input logic              core_deep_sleep,
   input logic              pwr_en,
   input logic              clk_en,
   input logic              iso_en,
   input logic              core_rst,
   input logic              ret_en,
   input logic              state_done
);

   logic key_hit;
   assign key_hit = (wr_data[DATA_W-1 -: KEY_W] == KEY_WRITE[KEY_W-1:0]);

   assert_key_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && key_hit) |=> (rd_data[1:0] == $past(wr_data[1:0])));

   assert_bad_key_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !key_hit) |=> $stable(rd_data));

   assert_readback_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[DATA_W-1 -: KEY_W] == KEY_READ[KEY_W-1:0]) &&
      (rd_data[DATA_W-KEY_W-1:2] == '0));

   assert_clk_needs_pwr_R7: assert property (@(posedge clk) disable iff (!rst_n)
      clk_en |-> pwr_en);

   assert_retain_shape_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ret_en |-> (iso_en && !pwr_en && !core_rst && !clk_en));

   assert_retain_after_sleep_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ret_en) |-> $past(core_deep_sleep));

   assert_pwrup_safe_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwr_en) |-> (!clk_en && iso_en && core_rst && !ret_en));

   assert_done_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && key_hit && (wr_data[1:0] != rd_data[1:0])) |=> !state_done);

endmodule

bind core_pwr_ctl core_pwr_ctl_chk #(
   .DATA_W    (DATA_W),
   .KEY_W     (KEY_W),
   .KEY_WRITE (KEY_WRITE),
   .KEY_READ  (KEY_READ)
) u_chk (.*);

// File: tb/test_core_pwr_ctl.sv
module test_core_pwr_ctl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        core_deep_sleep = 1'b0;
   logic        pwr_en, clk_en, iso_en, core_rst, ret_en, state_done;

   int checks = 0;
   int failures = 0;

   always #2.5 clk = ~clk;

   core_pwr_ctl i_core_pwr_ctl (
      .clk             (clk),
      .rst_n           (rst_n),
      .wr_en           (wr_en),
      .wr_data         (wr_data),
      .rd_data         (rd_data),
      .core_deep_sleep (core_deep_sleep),
      .pwr_en          (pwr_en),
      .clk_en          (clk_en),
      .iso_en          (iso_en),
      .core_rst        (core_rst),
      .ret_en          (ret_en),
      .state_done      (state_done)
   );

   // Output order {pwr, clk, iso, rst, ret}
   localparam logic [4:0] O_OFF = 5'b00110;
   localparam logic [4:0] O_RST = 5'b10010;
   localparam logic [4:0] O_RET = 5'b00101;
   localparam logic [4:0] O_ON  = 5'b11000;
   localparam logic [4:0] O_PUP = 5'b10110;

   // {wr_data[31:0], deep_sleep, expected rd_data[31:0], expected outputs[4:0]}
   localparam int NV = 7;
   localparam logic [69:0] VEC [0:NV-1] = '{
      {32'h05FA0003, 1'b0, 32'hFA050003, O_ON },
      {32'h12340000, 1'b0, 32'hFA050003, O_ON },
      {32'h05FA0000, 1'b0, 32'hFA050000, O_OFF},
      {32'h05FAFFF1, 1'b0, 32'hFA050001, O_RST},
      {32'h05FA0002, 1'b1, 32'hFA050002, O_RET},
      {32'hFA050003, 1'b1, 32'hFA050002, O_RET},
      {32'h05FA0003, 1'b0, 32'hFA050003, O_ON }
   };

   function automatic logic [4:0] outs();
      return {pwr_en, clk_en, iso_en, core_rst, ret_en};
   endfunction

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   // Drive at the falling edge, return at the next falling edge (write edge passed).
   task automatic write(input logic [31:0] d);
      wr_en   = 1'b1;
      wr_data = d;
      @(negedge clk);
      wr_en   = 1'b0;
      wr_data = '0;
   endtask

   task automatic step(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   initial begin
      #(5ns * 20000);
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      // R1 reset state
      check("R1 rd", rd_data, 32'hFA050001);
      check("R1 outs", {27'd0, outs()}, {27'd0, O_RST});
      check("R1 done", {31'd0, state_done}, 32'd1);

      // Vector walk: R2 R3 R4 R5 R6 R7 R8 R9
      for (int i = 0; i < NV; i++) begin
         core_deep_sleep = VEC[i][37];
         step(1);
         write(VEC[i][69:38]);
         step(3);
         check("R2/R3/R4 rd", rd_data, VEC[i][36:5]);
         check("R5-R8 outs", {27'd0, outs()}, {27'd0, VEC[i][4:0]});
         check("R10 done settled", {31'd0, state_done}, 32'd1);
      end

      // Direct path 3 -> 0, R5 and R10 timing
      write(32'h05FA0000);
      check("R2 rd after edge", rd_data, 32'hFA050000);
      check("R10 done cleared", {31'd0, state_done}, 32'd0);
      check("R5 outs not yet", {27'd0, outs()}, {27'd0, O_ON});
      step(1);
      check("R5 outs off", {27'd0, outs()}, {27'd0, O_OFF});
      check("R10 done one more", {31'd0, state_done}, 32'd0);
      step(1);
      check("R10 done rises", {31'd0, state_done}, 32'd1);

      // Power-up step 0 -> 3, R9
      write(32'h05FA0003);
      check("R9 outs hold", {27'd0, outs()}, {27'd0, O_OFF});
      step(1);
      check("R9 pwrup step", {27'd0, outs()}, {27'd0, O_PUP});
      check("R9 done low", {31'd0, state_done}, 32'd0);
      step(1);
      check("R9 target on", {27'd0, outs()}, {27'd0, O_ON});
      check("R10 done low", {31'd0, state_done}, 32'd0);
      step(1);
      check("R10 done high", {31'd0, state_done}, 32'd1);

      // Deferred retain, R8
      core_deep_sleep = 1'b0;
      write(32'h05FA0002);
      step(4);
      check("R8 held outs", {27'd0, outs()}, {27'd0, O_ON});
      check("R8 done low", {31'd0, state_done}, 32'd0);
      check("R8 rd", rd_data, 32'hFA050002);
      core_deep_sleep = 1'b1;
      step(1);
      check("R8 retain applied", {27'd0, outs()}, {27'd0, O_RET});
      check("R10 done lag", {31'd0, state_done}, 32'd0);
      step(1);
      check("R10 retain done", {31'd0, state_done}, 32'd1);
      core_deep_sleep = 1'b0;
      step(2);
      check("R8 stays retained", {27'd0, outs()}, {27'd0, O_RET});

      // Same-mode write keeps done, R10
      write(32'h05FA0002);
      check("R10 same mode", {31'd0, state_done}, 32'd1);

      // Wrong key leaves everything, R3
      write(32'h05FB0001);
      step(2);
      check("R3 rd", rd_data, 32'hFA050002);
      check("R3 outs", {27'd0, outs()}, {27'd0, O_RET});
      check("R3 done", {31'd0, state_done}, 32'd1);

      // Retain -> reset passes power-up, R6 R9
      write(32'h05FA0001);
      step(1);
      check("R9 pwrup from retain", {27'd0, outs()}, {27'd0, O_PUP});
      step(1);
      check("R6 reset outs", {27'd0, outs()}, {27'd0, O_RST});

      // Reset again, R1
      rst_n = 1'b0;
      step(1);
      rst_n = 1'b1;
      step(1);
      check("R1 rd again", rd_data, 32'hFA050001);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule